// File: doc/BRIEF.md
# Chaotic Iteration Bit-Flip Generator

The block holds a small state word and, each time a sample strobe arrives, inverts exactly one of its bits. Which bit is inverted comes from a strategy index. An external bank of level comparators supplies that index as a thermometer code. The block synchronizes the thermometer word, registers it when the strobe is high, and turns it into a one-hot mask. It then XORs the mask into the state. The state word is the unsigned code that a downstream converter would turn into an output level.

Software or a controlling block may load a seed into the state at any time. A thermometer word that is not one of the legal patterns is rejected, and a sticky error flag records it. After every completed iteration, a one-cycle valid pulse marks the new state, index and mask.

Top module: `cbf_bitflip_gen`

## Requirements
- R1: In the first cycle after synchronous reset, state_o, idx_o and mask_o are all zero, and valid_o and err_o are low.
- R2: When seed_ld is high at a clock edge, state_o equals seed_val from the following cycle. In that case valid_o stays low and idx_o and mask_o keep their values.
- R3: The legal thermometer codes, LSB first filled, are 0001, 0011, 0111 and 1111. They give idx_o 0, 1, 2 and 3 and mask_o 0001, 0010, 0100 and 1000. Mask bit N-1 equals thermometer bit N-1, and every lower mask bit i equals thermometer bit i+1 XOR thermometer bit i.
- R4: An accepted iteration makes the new state_o equal to the old state_o XOR mask_o, so exactly one bit changes.
- R5: A thermometer code that is not legal (bit 0 clear, or a 1 above a 0, for example 0000 or 0101) leaves state_o, idx_o and mask_o unchanged. valid_o does not pulse for it, and err_o goes high.
- R6: When seed_ld is high at the same edge where an iteration would apply, the seed is written and the iteration is discarded.
- R7: For a strobe that is high at clock edge E, the results appear after edge E+1, and valid_o is high for exactly the one cycle following E+1. Between iterations and seed loads, state_o does not change.
- R8: therm_in passes through a two-flop synchronizer and is captured only at an edge where strobe is high. Changing therm_in while strobe is low, or after the capturing edge, has no effect on the outputs.
- R9: Once err_o is set, it stays high until reset, even through later legal iterations and seed loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_ld | input | 1 | Load seed_val into the state |
| seed_val | input | N | Seed value for the state |
| strobe | input | 1 | Sample strobe, one iteration per high cycle |
| therm_in | input | N | Thermometer code from the comparator bank |
| state_o | output | N | Current state word |
| idx_o | output | IW | Strategy index of the last accepted iteration |
| mask_o | output | N | One-hot mask of the last accepted iteration |
| valid_o | output | 1 | One-cycle pulse after each completed iteration |
| err_o | output | 1 | Sticky flag for an illegal thermometer code |

## Verification
Several properties are checked on every cycle:
- each valid pulse changes exactly one state bit, and its mask agrees with its index;
- the state holds still unless a valid pulse or a seed load explains the change;
- a seed lands one cycle after seed_ld;
- a valid pulse always follows a strobe two cycles earlier;
- the error flag never clears on its own.

The bench scenarios cover what those properties cannot show: the exact thermometer-to-index table, the rejection of illegal codes with the state unchanged, the synchronizer capture point when therm_in moves around a strobe, and the seed winning over a pending iteration.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    localparam int DEF_WIDTH       = 4;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_SEED   = 2'd1,
        UPD_FLIP   = 2'd2,
        UPD_REJECT = 2'd3
    } upd_kind_e;

    function automatic int idx_bits(input int width);
        return (width > 1) ? $clog2(width) : 1;
    endfunction

endpackage

// File: rtl/cbf_therm_sync.sv
module cbf_therm_sync #(
    parameter int W      = cbf_pkg::DEF_WIDTH,
    parameter int STAGES = cbf_pkg::DEF_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cbf_therm_decode.sv
module cbf_therm_decode #(
    parameter int W  = cbf_pkg::DEF_WIDTH,
    parameter int IW = cbf_pkg::idx_bits(W)
) (
    input  logic [W-1:0]  therm,
    output logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          legal
);
    logic [W-1:0] therm_inc;

    // Edge detector between neighbouring comparator outputs.
    for (genvar b = 0; b < W; b++) begin : g_mask
        if (b == W - 1) begin : g_top
            assign mask[b] = therm[b];
        end else begin : g_low
            assign mask[b] = therm[b+1] ^ therm[b];
        end
    end

    // Highest set bit gives the index of a legal code.
    always_comb begin
        idx = '0;
        for (int b = 1; b < W; b++) begin
            if (therm[b]) idx = IW'(b);
        end
    end

    // Legal: bit 0 set and ones contiguous from the LSB.
    assign therm_inc = therm + W'(1);
    assign legal     = therm[0] && ((therm & therm_inc) == '0);
endmodule

// File: rtl/cbf_state.sv
module cbf_state
    import cbf_pkg::*;
#(
    parameter int W  = DEF_WIDTH,
    parameter int IW = idx_bits(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_ld,
    input  logic [W-1:0]  seed_val,
    input  logic          pend,
    input  logic          legal,
    input  logic [W-1:0]  mask_in,
    input  logic [IW-1:0] idx_in,
    output logic [W-1:0]  state_q,
    output logic [IW-1:0] idx_q,
    output logic [W-1:0]  mask_q,
    output logic          valid_q,
    output logic          err_q
);
    upd_kind_e kind;

    always_comb begin
        if (seed_ld)    kind = UPD_SEED;
        else if (!pend) kind = UPD_HOLD;
        else if (legal) kind = UPD_FLIP;
        else            kind = UPD_REJECT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            idx_q   <= '0;
            mask_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (kind)
                UPD_SEED: state_q <= seed_val;
                UPD_FLIP: begin
                    state_q <= state_q ^ mask_in;
                    idx_q   <= idx_in;
                    mask_q  <= mask_in;
                    valid_q <= 1'b1;
                end
                UPD_REJECT: err_q <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cbf_bitflip_gen.sv
module cbf_bitflip_gen
    import cbf_pkg::*;
#(
    parameter int N           = DEF_WIDTH,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int IW         = idx_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_ld,
    input  logic [N-1:0]  seed_val,
    input  logic          strobe,
    input  logic [N-1:0]  therm_in,
    output logic [N-1:0]  state_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  mask_o,
    output logic          valid_o,
    output logic          err_o
);
    logic [N-1:0]  therm_sync;
    logic [N-1:0]  cap_q;
    logic          pend_q;
    logic [N-1:0]  dec_mask;
    logic [IW-1:0] dec_idx;
    logic          dec_legal;

    cbf_therm_sync #(.W(N), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (therm_in),
        .q   (therm_sync)
    );

    // Capture register: holds the code sampled on the strobe cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= strobe;
            if (strobe) cap_q <= therm_sync;
        end
    end

    cbf_therm_decode #(.W(N), .IW(IW)) dec_i (
        .therm (cap_q),
        .mask  (dec_mask),
        .idx   (dec_idx),
        .legal (dec_legal)
    );

    cbf_state #(.W(N), .IW(IW)) st_i (
        .clk      (clk),
        .rst      (rst),
        .seed_ld  (seed_ld),
        .seed_val (seed_val),
        .pend     (pend_q),
        .legal    (dec_legal),
        .mask_in  (dec_mask),
        .idx_in   (dec_idx),
        .state_q  (state_o),
        .idx_q    (idx_o),
        .mask_q   (mask_o),
        .valid_q  (valid_o),
        .err_q    (err_o)
    );
endmodule

// File: rtl/cbf_bitflip_chk.sv
module cbf_bitflip_chk #(
    parameter int N  = cbf_pkg::DEF_WIDTH,
    parameter int IW = cbf_pkg::idx_bits(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          seed_ld,
    input logic [N-1:0]  seed_val,
    input logic          strobe,
    input logic [N-1:0]  state_o,
    input logic [IW-1:0] idx_o,
    input logic [N-1:0]  mask_o,
    input logic          valid_o,
    input logic          err_o
);
    p_seed_lands_r2: assert property (@(posedge clk) disable iff (rst)
        seed_ld |=> state_o == $past(seed_val));

    p_mask_matches_idx_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> mask_o == (N'(1) << idx_o));

    p_single_flip_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $countones(state_o ^ $past(state_o)) == 1);

    p_state_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !$past(seed_ld)) |-> $stable(state_o));

    p_valid_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(strobe, 2));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind cbf_bitflip_gen cbf_bitflip_chk #(.N(N), .IW(IW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .seed_ld  (seed_ld),
    .seed_val (seed_val),
    .strobe   (strobe),
    .state_o  (state_o),
    .idx_o    (idx_o),
    .mask_o   (mask_o),
    .valid_o  (valid_o),
    .err_o    (err_o)
);

// File: tb/cbf_bitflip_gen_tb_top.sv
`timescale 1ns/1ps
module cbf_bitflip_gen_tb_top;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int NV = 8;

    localparam logic [N-1:0]  V_THERM [NV] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111,
                                               4'b0011, 4'b0011, 4'b1111, 4'b0001};
    localparam logic [IW-1:0] V_IDX   [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd1, 2'd3, 2'd0};
    localparam logic [N-1:0]  V_MASK  [NV] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                               4'b0010, 4'b0010, 4'b1000, 4'b0001};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seed_ld = 1'b0;
    logic [N-1:0]  seed_val = '0;
    logic          strobe = 1'b0;
    logic [N-1:0]  therm_in = '0;
    logic [N-1:0]  state_o;
    logic [IW-1:0] idx_o;
    logic [N-1:0]  mask_o;
    logic          valid_o;
    logic          err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [N-1:0]  model;

    always #4 clk = ~clk;

    cbf_bitflip_gen #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .seed_ld(seed_ld), .seed_val(seed_val),
        .strobe(strobe), .therm_in(therm_in), .state_o(state_o),
        .idx_o(idx_o), .mask_o(mask_o), .valid_o(valid_o), .err_o(err_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a code, let it settle through the synchronizer, strobe once.
    // Returns after edge E (strobe edge) has passed.
    task automatic strobe_code(input logic [N-1:0] code);
        therm_in = code;
        repeat (3) @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 state", 8'(state_o), 8'h0);
        check("R1 idx", 8'(idx_o), 8'h0);
        check("R1 mask", 8'(mask_o), 8'h0);
        check("R1 valid", 8'(valid_o), 8'h0);
        check("R1 err", 8'(err_o), 8'h0);
        model = '0;

        // R3 / R4 / R7: table walk
        for (int v = 0; v < NV; v++) begin
            strobe_code(V_THERM[v]);
            @(negedge clk);
            model = model ^ V_MASK[v];
            check("R3 idx", 8'(idx_o), 8'(V_IDX[v]));
            check("R3 mask", 8'(mask_o), 8'(V_MASK[v]));
            check("R4 state", 8'(state_o), 8'(model));
            check("R7 valid high", 8'(valid_o), 8'h1);
            @(negedge clk);
            check("R7 valid one cycle", 8'(valid_o), 8'h0);
            check("R7 state stable", 8'(state_o), 8'(model));
        end

        // R2 seed load
        seed_val = 4'b0110;
        seed_ld = 1'b1;
        @(negedge clk);
        seed_ld = 1'b0;
        model = 4'b0110;
        check("R2 seed state", 8'(state_o), 8'h6);
        check("R2 seed no valid", 8'(valid_o), 8'h0);
        check("R2 idx kept", 8'(idx_o), 8'(V_IDX[NV-1]));

        // R8: therm_in moves without strobe
        therm_in = 4'b1111;
        repeat (6) @(negedge clk);
        therm_in = 4'b0011;
        repeat (6) @(negedge clk);
        check("R8 no strobe state", 8'(state_o), 8'(model));
        check("R8 no strobe valid", 8'(valid_o), 8'h0);

        // R8: change immediately after the capturing edge
        strobe_code(4'b0111);
        therm_in = 4'b1111;
        @(negedge clk);
        model = model ^ 4'b0100;
        check("R8 captured idx", 8'(idx_o), 8'h2);
        check("R8 captured state", 8'(state_o), 8'(model));
        repeat (5) @(negedge clk);
        check("R8 later no change", 8'(state_o), 8'(model));

        // R6: seed collides with a pending iteration
        strobe_code(4'b0001);
        seed_val = 4'b1010;
        seed_ld = 1'b1;
        @(negedge clk);
        seed_ld = 1'b0;
        model = 4'b1010;
        check("R6 seed wins", 8'(state_o), 8'hA);
        check("R6 no valid", 8'(valid_o), 8'h0);
        check("R6 idx kept", 8'(idx_o), 8'h2);
        @(negedge clk);
        check("R6 still seed", 8'(state_o), 8'hA);

        // R5: illegal codes
        check("R5 err before", 8'(err_o), 8'h0);
        strobe_code(4'b0000);
        @(negedge clk);
        check("R5 0000 state", 8'(state_o), 8'(model));
        check("R5 0000 valid", 8'(valid_o), 8'h0);
        check("R5 0000 err", 8'(err_o), 8'h1);
        strobe_code(4'b0101);
        @(negedge clk);
        check("R5 0101 state", 8'(state_o), 8'(model));
        check("R5 0101 idx", 8'(idx_o), 8'h2);
        check("R5 0101 mask", 8'(mask_o), 8'h4);

        // R9: sticky through a legal iteration and a seed
        strobe_code(4'b1111);
        @(negedge clk);
        model = model ^ 4'b1000;
        check("R9 legal after err state", 8'(state_o), 8'(model));
        check("R9 err held", 8'(err_o), 8'h1);
        seed_val = 4'b0001;
        seed_ld = 1'b1;
        @(negedge clk);
        seed_ld = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 err held after seed", 8'(err_o), 8'h1);

        // R1: reset clears error and state
        do_reset();
        check("R1 err cleared", 8'(err_o), 8'h0);
        check("R1 state cleared", 8'(state_o), 8'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule